// File: doc/BRIEF.md
# Byte PRBS Error-Ratio Meter

This block estimates how well a high-speed receiver is sampling at a given phase. The receiver's 8b/10b decoder delivers bytes, a strobe marking each valid byte, and a flag that is high once the byte boundaries have been found on the comma character. The block regenerates a PRBS-7 reference locally and locks it to the incoming stream. It then counts how many bytes arrived and how many of them differed from the reference. Because the comparison happens after decoding, the unit of error is a whole byte.

A host controls the block over a four-wire SPI slave port. A phase write does three things: it drives the 7-bit phase-select output that steers the external sampling-delay circuit, it clears both counters, and it starts a measurement. The measurement first lets the new phase settle for a fixed number of byte clocks. It then counts over a window of a fixed number of byte clocks. The host polls a status byte and then reads the two 32-bit counters one byte at a time. Sweeping all 128 phases this way gives the points of a bathtub curve.

Top module: `prbs_ber_meter`

## Requirements
- R1: The reference is PRBS-7 with recurrence b[n] = b[n-7] XOR b[n-6] (polynomial x^7 + x^6 + 1). Eight sequence bits form one byte, the earliest bit in bit 7. The last seven bits of a byte (bits 6..0) form the state from which the next byte is predicted. A clean locked stream inside a window gives an error count of 0 and a total equal to the number of bytes sent.
- R2: A counted byte that differs from the reference raises the error count by exactly one, whether one bit or all eight bits differ. The error count never exceeds the total count.
- R3: After alignment is gained, the first valid byte only seeds the reference. Lock is declared after 16 further consecutive matching bytes, so counting starts with the 18th aligned byte. A zero reference state never counts as a match, so an all-zero stream never locks.
- R4: Bytes that arrive while the aligned flag is low are never counted. A low aligned flag also clears the lock and the reference state.
- R5: SPI runs in mode 0 (MOSI sampled on rising SCLK, MISO changed on falling SCLK, MSB first) with 16-bit frames framed by an active-low select. The first byte is the command and the second byte carries data. Command 0x01 loads bits 6..0 of the data byte into phaseSel and ignores bit 7. No other command changes phaseSel.
- R6: During the second byte of a frame with command 0x02, MISO returns a status byte: bit 0 is set while a measurement is settling or counting, and bit 1 is set once a window has completed. After reset the status byte is 0x00.
- R7: Commands 0x03 to 0x06 return the 32-bit total count and commands 0x07 to 0x0A return the 32-bit error count, each from the most significant byte down. A narrower counter is zero-extended. Any other command returns 0x00.
- R8: Command 0x01 clears both counters. For the next SETTLE_CYCLES byte clocks (256 by default), no byte is counted.
- R9: The counting window then lasts WINDOW_BYTES byte clocks, after which the block reports done. Bytes that arrive after the window are not counted.
- R10: Both counters stop at their all-ones value instead of wrapping.
- R11: A phase write that arrives while bytes are being counted takes priority. The old counts are discarded, and only bytes of the new window are counted.
- R12: After reset, phaseSel is 0 and both counters read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxData | input | 8 | Decoded received byte |
| rxValid | input | 1 | rxData holds a byte this cycle |
| rxAligned | input | 1 | Byte boundaries are locked to the comma |
| spiSclk | input | 1 | SPI serial clock from the host |
| spiCsN | input | 1 | SPI select, active low |
| spiMosi | input | 1 | SPI data from the host |
| spiMiso | output | 1 | SPI data to the host |
| phaseSel | output | 7 | Sampling-phase selection, 128 steps |

## Verification
Two functions can meet in the same byte clock. One is the counter clear issued by a completed phase-write frame. The other is the increment for a byte being counted in the running window. The bench provokes this by streaming bytes, some of them corrupted, while a new phase write is shifted in over SPI. It stops the stream before the new settle period ends, then sends a known number of clean bytes inside the new window. The read-back total and error counts must equal exactly those new bytes, with no residue from the stream that overlapped the clear.

// File: rtl/berm_pkg.sv
package berm_pkg;

  typedef struct packed {
    logic clearCnt;
    logic countEn;
  } berm_strobe_t;

  typedef enum logic [1:0] {
    MS_IDLE   = 2'd0,
    MS_SETTLE = 2'd1,
    MS_WINDOW = 2'd2,
    MS_DONE   = 2'd3
  } berm_state_t;

  // Next PRBS-7 byte (x^7 + x^6 + 1), earliest bit in bit 7.
  function automatic logic [7:0] prbsByte(input logic [6:0] seed);
    logic [6:0] s;
    logic       nb;
    logic [7:0] b;
    s = seed;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      nb       = s[6] ^ s[5];
      b[7 - i] = nb;
      s        = {s[5:0], nb};
    end
    return b;
  endfunction

endpackage

// File: rtl/berm_datapath.sv
module berm_datapath
  import berm_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int LOCK_RUN = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       rxData,
  input  logic             rxValid,
  input  logic             rxAligned,
  input  berm_strobe_t     strobes,
  output logic [CNT_W-1:0] totalCnt,
  output logic [CNT_W-1:0] errCnt
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [6:0]       refState;
  logic [RUN_W-1:0] matchRun;
  logic             locked;
  logic [7:0]       predByte;
  logic             byteBad;
  logic             seedOk;
  logic             countHit;

  assign predByte = prbsByte(refState);
  assign byteBad  = (rxData != predByte);
  assign seedOk   = (refState != 7'd0);
  assign countHit = strobes.countEn && rxValid && rxAligned && locked;

  // reference tracking and lock
  always_ff @(posedge clk) begin
    if (!rstN || !rxAligned) begin
      refState <= '0;
      matchRun <= '0;
      locked   <= 1'b0;
    end else if (rxValid) begin
      if (locked) begin
        refState <= predByte[6:0];
      end else begin
        refState <= rxData[6:0];
        if (seedOk && !byteBad) begin
          matchRun <= matchRun + 1'b1;
          if (matchRun == RUN_W'(LOCK_RUN - 1)) locked <= 1'b1;
        end else begin
          matchRun <= '0;
        end
      end
    end
  end

  // saturating counters, clear has priority
  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearCnt) begin
      totalCnt <= '0;
      errCnt   <= '0;
    end else if (countHit) begin
      if (totalCnt != CNT_MAX) totalCnt <= totalCnt + 1'b1;
      if (byteBad && errCnt != CNT_MAX) errCnt <= errCnt + 1'b1;
    end
  end

endmodule

// File: rtl/berm_ctrl.sv
module berm_ctrl
  import berm_pkg::*;
#(
  parameter int CNT_W         = 32,
  parameter int SETTLE_CYCLES = 256,
  parameter int WINDOW_BYTES  = 17_500_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             spiSclk,
  input  logic             spiCsN,
  input  logic             spiMosi,
  output logic             spiMiso,
  input  logic [CNT_W-1:0] totalCnt,
  input  logic [CNT_W-1:0] errCnt,
  output logic [6:0]       phaseSel,
  output berm_strobe_t     strobes,
  output logic             startPulse,
  output logic             busy,
  output logic             done
);
  localparam int TMR_MAX = (SETTLE_CYCLES > WINDOW_BYTES) ? SETTLE_CYCLES : WINDOW_BYTES;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  logic [2:0]       sclkSync;
  logic [1:0]       csSync;
  logic [1:0]       mosiSync;
  logic             sclkRise, sclkFall, csActive;
  logic [4:0]       bitCnt;
  logic [14:0]      rxShift;
  logic [7:0]       txShift;
  logic [7:0]       cmdNow;
  logic [31:0]      totalExt, errExt;
  logic [7:0]       respByte;
  berm_state_t      mState;
  logic [TMR_W-1:0] timer;

  assign sclkRise = sclkSync[1] & ~sclkSync[2];
  assign sclkFall = ~sclkSync[1] & sclkSync[2];
  assign csActive = ~csSync[1];
  assign cmdNow   = {rxShift[6:0], mosiSync[1]};
  assign totalExt = 32'(totalCnt);
  assign errExt   = 32'(errCnt);
  assign busy     = (mState == MS_SETTLE) || (mState == MS_WINDOW);
  assign done     = (mState == MS_DONE);

  assign startPulse = csActive && sclkRise && (bitCnt == 5'd15) && (rxShift[14:7] == 8'h01);
  assign strobes.clearCnt = startPulse;
  assign strobes.countEn  = (mState == MS_WINDOW);
  assign spiMiso = csActive && (bitCnt >= 5'd8) ? txShift[7] : 1'b0;

  always_comb begin
    case (cmdNow)
      8'h02:   respByte = {6'd0, done, busy};
      8'h03:   respByte = totalExt[31:24];
      8'h04:   respByte = totalExt[23:16];
      8'h05:   respByte = totalExt[15:8];
      8'h06:   respByte = totalExt[7:0];
      8'h07:   respByte = errExt[31:24];
      8'h08:   respByte = errExt[23:16];
      8'h09:   respByte = errExt[15:8];
      8'h0A:   respByte = errExt[7:0];
      default: respByte = 8'h00;
    endcase
  end

  // SPI slave, mode 0, oversampled by the byte clock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      mosiSync <= '0;
      bitCnt   <= '0;
      rxShift  <= '0;
      txShift  <= '0;
      phaseSel <= '0;
    end else begin
      sclkSync <= {sclkSync[1:0], spiSclk};
      csSync   <= {csSync[0], spiCsN};
      mosiSync <= {mosiSync[0], spiMosi};
      if (!csActive) begin
        bitCnt <= '0;
      end else if (sclkRise) begin
        rxShift <= {rxShift[13:0], mosiSync[1]};
        bitCnt  <= bitCnt + 1'b1;
        if (bitCnt == 5'd7) txShift <= respByte;
        if (startPulse) phaseSel <= cmdNow[6:0];
      end else if (sclkFall && bitCnt > 5'd8) begin
        txShift <= {txShift[6:0], 1'b0};
      end
    end
  end

  // measurement sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mState <= MS_IDLE;
      timer  <= '0;
    end else if (startPulse) begin
      mState <= MS_SETTLE;
      timer  <= '0;
    end else begin
      case (mState)
        MS_SETTLE: begin
          if (timer == TMR_W'(SETTLE_CYCLES - 1)) begin
            mState <= MS_WINDOW;
            timer  <= '0;
          end else timer <= timer + 1'b1;
        end
        MS_WINDOW: begin
          if (timer == TMR_W'(WINDOW_BYTES - 1)) begin
            mState <= MS_DONE;
            timer  <= '0;
          end else timer <= timer + 1'b1;
        end
        default: timer <= '0;
      endcase
    end
  end

endmodule

// File: rtl/prbs_ber_meter.sv
module prbs_ber_meter
  import berm_pkg::*;
#(
  parameter int CNT_W         = 32,
  parameter int SETTLE_CYCLES = 256,
  parameter int WINDOW_BYTES  = 17_500_000,
  parameter int LOCK_RUN      = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] rxData,
  input  logic       rxValid,
  input  logic       rxAligned,
  input  logic       spiSclk,
  input  logic       spiCsN,
  input  logic       spiMosi,
  output logic       spiMiso,
  output logic [6:0] phaseSel
);
  berm_strobe_t     strobes;
  logic [CNT_W-1:0] totalCnt;
  logic [CNT_W-1:0] errCnt;
  logic             startPulse;
  logic             busy;
  logic             done;

  berm_ctrl #(
    .CNT_W(CNT_W), .SETTLE_CYCLES(SETTLE_CYCLES), .WINDOW_BYTES(WINDOW_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .totalCnt(totalCnt), .errCnt(errCnt),
    .phaseSel(phaseSel), .strobes(strobes),
    .startPulse(startPulse), .busy(busy), .done(done)
  );

  berm_datapath #(
    .CNT_W(CNT_W), .LOCK_RUN(LOCK_RUN)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .rxData(rxData), .rxValid(rxValid), .rxAligned(rxAligned),
    .strobes(strobes),
    .totalCnt(totalCnt), .errCnt(errCnt)
  );

endmodule

// File: rtl/berm_checker.sv
module berm_checker
  import berm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxAligned,
  input berm_strobe_t     strobes,
  input logic             startPulse,
  input logic             busy,
  input logic             done,
  input logic [6:0]       phaseSel,
  input logic [CNT_W-1:0] totalCnt,
  input logic [CNT_W-1:0] errCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R2
  err_le_total_chk: assert property (@(posedge clk) disable iff (!rstN)
    errCnt <= totalCnt);

  // R2
  total_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clearCnt |=> (totalCnt == $past(totalCnt)) || (totalCnt == $past(totalCnt) + 1'b1));

  // R4
  unaligned_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rxAligned && !strobes.clearCnt) |=> $stable(totalCnt) && $stable(errCnt));

  // R8
  outside_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.countEn && !strobes.clearCnt) |=> $stable(totalCnt) && $stable(errCnt));

  // R10
  total_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (totalCnt == CNT_MAX && !strobes.clearCnt) |=> totalCnt == CNT_MAX);

  // R11
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearCnt |=> (totalCnt == '0) && (errCnt == '0));

  // R6
  status_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busy, done}));

  // R5
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !startPulse |=> $stable(phaseSel));

endmodule

bind prbs_ber_meter berm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .rxAligned(rxAligned), .strobes(strobes),
  .startPulse(startPulse), .busy(busy), .done(done), .phaseSel(phaseSel),
  .totalCnt(totalCnt), .errCnt(errCnt)
);

// File: tb/prbs_ber_meter_bench.sv
module prbs_ber_meter_bench;
  localparam int CNT_W  = 12;
  localparam int SETTLE = 256;
  localparam int WINDOW = 6000;
  localparam int HALF   = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] rxData = 8'd0;
  logic       rxValid = 1'b0;
  logic       rxAligned = 1'b0;
  logic       spiSclk = 1'b0;
  logic       spiCsN = 1'b1;
  logic       spiMosi = 1'b0;
  logic       spiMiso;
  logic [6:0] phaseSel;

  int checkCnt = 0;
  int failCnt = 0;
  logic [6:0] tbState = 7'h5A;

  always #2 clk = ~clk;

  prbs_ber_meter #(
    .CNT_W(CNT_W), .SETTLE_CYCLES(SETTLE), .WINDOW_BYTES(WINDOW)
  ) u_prbs_ber_meter (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxValid(rxValid), .rxAligned(rxAligned),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .phaseSel(phaseSel)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Bench model of the reference sequence: b[n] = b[n-7] ^ b[n-6], earliest bit in bit 7
  function automatic logic [7:0] tbNext(input logic [6:0] s);
    logic [7:0] b;
    logic [6:0] st;
    st = s;
    for (int i = 7; i >= 0; i--) begin
      b[i] = st[6] ^ st[5];
      st = {st[5:0], b[i]};
    end
    return b;
  endfunction

  task automatic sendRaw(input logic [7:0] d, input logic al);
    rxData = d; rxValid = 1'b1; rxAligned = al;
    tick();
    rxValid = 1'b0;
  endtask

  task automatic sendPrbs(input int n, input logic [7:0] mask, input logic al);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      b = tbNext(tbState);
      tbState = b[6:0];
      sendRaw(b ^ mask, al);
    end
  endtask

  task automatic spiXfer(input logic [7:0] cmd, input logic [7:0] dat, output logic [7:0] resp);
    logic [15:0] frame;
    frame = {cmd, dat};
    resp = 8'd0;
    spiCsN = 1'b0;
    tick(HALF);
    for (int i = 15; i >= 0; i--) begin
      spiMosi = frame[i];
      tick(HALF);
      if (i < 8) resp[i] = spiMiso;
      spiSclk = 1'b1;
      tick(HALF);
      spiSclk = 1'b0;
    end
    tick(HALF);
    spiCsN = 1'b1;
    tick(HALF);
  endtask

  task automatic readCnt(input logic [7:0] base, output logic [31:0] val);
    logic [7:0] r;
    val = 32'd0;
    for (int i = 0; i < 4; i++) begin
      spiXfer(base + 8'(i), 8'h00, r);
      val = {val[23:0], r};
    end
  endtask

  task automatic startMeas(input logic [7:0] ph);
    logic [7:0] r;
    spiXfer(8'h01, ph, r);
  endtask

  task automatic checkCounts(input string req, input logic [31:0] expTot, input logic [31:0] expErr);
    logic [31:0] v;
    readCnt(8'h03, v); check({req, " total"}, v, expTot);
    readCnt(8'h07, v); check({req, " errors"}, v, expErr);
  endtask

  task automatic testReset();
    logic [7:0] r;
    check("R12 phaseSel", 32'(phaseSel), 32'd0);
    spiXfer(8'h02, 8'h00, r); check("R6 reset status", 32'(r), 32'h00);
    checkCounts("R12", 32'd0, 32'd0);
    spiXfer(8'h55, 8'h00, r); check("R7 unknown command", 32'(r), 32'h00);
  endtask

  task automatic testPhase();
    logic [7:0] r;
    startMeas(8'hD5);
    check("R5 phase bit7 ignored", 32'(phaseSel), 32'h55);
    spiXfer(8'h02, 8'h00, r); check("R6 busy", 32'(r), 32'h01);
    spiXfer(8'h04, 8'h00, r); check("R5 read leaves phase", 32'(phaseSel), 32'h55);
    tick(SETTLE + WINDOW);
    spiXfer(8'h02, 8'h00, r); check("R6 done", 32'(r), 32'h02);
  endtask

  task automatic testClean();
    logic [31:0] v;
    sendPrbs(20, 8'h00, 1'b1);           // lock while idle, not counted
    startMeas(8'h0A);
    tick(300);
    sendPrbs(500, 8'h00, 1'b1);
    tick(SETTLE + WINDOW);
    checkCounts("R1 clean stream", 32'd500, 32'd0);
    sendPrbs(50, 8'h00, 1'b1);           // after window
    readCnt(8'h03, v); check("R9 after window", v, 32'd500);
  endtask

  task automatic testErrors();
    startMeas(8'h11);
    tick(300);
    for (int k = 0; k < 400; k++) begin
      logic [7:0] m;
      m = 8'h00;
      if (k >= 50 && k < 60) m = 8'(1 << (k % 8));
      if (k >= 100 && k < 105) m = 8'hA5;
      if (k >= 200 && k < 203) m = 8'hFF;
      sendPrbs(1, m, 1'b1);
    end
    tick(SETTLE + WINDOW);
    checkCounts("R2 one per byte", 32'd400, 32'd18);
  endtask

  task automatic testSettle();
    startMeas(8'h22);
    sendPrbs(200, 8'h00, 1'b1);          // inside settle period
    tick(SETTLE + WINDOW);
    checkCounts("R8 settle not counted", 32'd0, 32'd0);
  endtask

  task automatic testAlign();
    startMeas(8'h33);
    tick(300);
    sendPrbs(30, 8'h00, 1'b1);
    sendPrbs(10, 8'h00, 1'b0);
    sendPrbs(25, 8'h00, 1'b1);           // seed + 16 to lock, 8 counted
    tick(SETTLE + WINDOW);
    checkCounts("R4 R3 realign", 32'd38, 32'd0);
  endtask

  task automatic testZero();
    startMeas(8'h44);
    tick(300);
    sendPrbs(1, 8'h00, 1'b0);
    for (int k = 0; k < 40; k++) sendRaw(8'h00, 1'b1);
    tick(SETTLE + WINDOW);
    checkCounts("R3 zeros never lock", 32'd0, 32'd0);
    sendPrbs(20, 8'h00, 1'b1);           // relock outside a window
  endtask

  task automatic testRestart();
    startMeas(8'h50);
    tick(300);
    sendPrbs(100, 8'h00, 1'b1);
    fork
      startMeas(8'h51);
      for (int k = 0; k < 400; k++) sendPrbs(1, (k % 37 == 0) ? 8'h0F : 8'h00, 1'b1);
    join
    tick(200);
    sendPrbs(60, 8'h00, 1'b1);
    tick(SETTLE + WINDOW);
    checkCounts("R11 restart clears", 32'd60, 32'd0);
    check("R5 new phase", 32'(phaseSel), 32'h51);
  endtask

  task automatic testSaturate();
    startMeas(8'h7F);
    tick(300);
    sendPrbs(4200, 8'hFF, 1'b1);
    tick(SETTLE + WINDOW);
    checkCounts("R10 saturation", 32'd4095, 32'd4095);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
  endtask

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(5);
    testReset();
    testPhase();
    testClean();
    testErrors();
    testSettle();
    testAlign();
    testZero();
    testRestart();
    testSaturate();
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

endmodule